// File: doc/BRIEF.md
# Per-Lane Link Training Word Generator

This block feeds one lane of a serial link transmitter during link training. It builds a 16-bit training word from three parts: a fixed header byte, a nibble that identifies the lane, and a 4-bit rolling sequence number. It hands each word to the downstream serializer as two bytes over a valid/ready handshake. The byte holding bit 0 goes first, so the word leaves least significant bit first once the serializer shifts each byte out LSB first.

The lane nibble depends on the lane's index and on whether the link runs at full width (16 lanes) or half width (lanes 0 to 7). A request to stop training lets the byte currently offered finish. After that byte, the block sends only zero (NULL) bytes. The stop can land between the two bytes of one word, so the point where NULL bytes begin does not mark any framing. A synchronous restart brings back training from the first byte of a word with sequence number 0.

Top module: `lane_train_gen`

## Requirements
- R1: While reset is held, out_valid is 0. The first byte offered after reset is the low byte of a word with sequence number 0, and out_valid stays 1 from then on.
- R2: Each word goes out as two transfers. The low byte comes first and holds {lane nibble in bits 7:4, sequence in bits 3:0}. The high byte comes second and is always 0xF0.
- R3: On lane index 0 the lane nibble is 0x3, at either width.
- R4: The lane nibble is 0xC on the highest lane. That is lane 15 when half_width is 0 and lane 7 when half_width is 1.
- R5: On every other lane the lane nibble is 0x5.
- R6: The sequence number goes up by one per completed word and wraps from 15 to 0, so the 32-byte pattern repeats every 16 words.
- R7: A byte is taken only on a clock edge where out_valid and out_ready are both 1. While out_ready is 0, out_data holds its value.
- R8: When stop_req is sampled, the byte being offered still goes out as a training byte. Every byte after it is 0x00, even when the stop falls between the low and high byte of one word. A stop sampled while the handshake is stalled takes effect after the next transfer.
- R9: NULL output continues after stop_req is deasserted, until a restart.
- R10: restart clears the sequence to 0, cancels a pending or completed stop and offers the low byte of a new word on the next cycle. It takes priority over stop_req in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_idx | input | 4 | Index of this lane (static during training) |
| half_width | input | 1 | 1 = half-width link (lanes 0..7), 0 = full width |
| restart | input | 1 | Synchronous restart of training |
| stop_req | input | 1 | Request to end training and send NULL bytes |
| out_ready | input | 1 | Serializer accepts the offered byte |
| out_data | output | 8 | Offered byte |
| out_valid | output | 1 | Byte on out_data is valid |

## Verification
Assertions check the cycle-level rules on every cycle: the low/high byte alternation on each transfer, the sequence step with its wrap, state held while stalled, the stop becoming NULL on a transfer, NULL persisting, and the state that follows a restart. The mapping from lane and width to the lane nibble, the actual byte values in their order, and the exact byte at which NULL output starts can only be shown by the bench. It sweeps every lane at both widths across a full pattern plus wrap, and it drives stops both mid-word and during a stall.

// File: rtl/ltg_pkg.sv
package ltg_pkg;
    localparam int SEQ_W   = 4;
    localparam int NIB_W   = 4;
    localparam int BYTE_W  = 8;
    localparam logic [BYTE_W-1:0] HDR_BYTE = 8'hF0;
    localparam logic [BYTE_W-1:0] NULL_BYTE = 8'h00;
    localparam logic [NIB_W-1:0] NIB_FIRST = 4'h3;
    localparam logic [NIB_W-1:0] NIB_LAST  = 4'hC;
    localparam logic [NIB_W-1:0] NIB_MID   = 4'h5;

    typedef struct packed {
        logic valid;
        logic phase;   // 0 = low byte next, 1 = high byte next
        logic nulled;
        logic pend;
    } tx_state_t;

    typedef struct packed {
        logic [SEQ_W-1:0] seq;
    } seq_state_t;
endpackage

// File: rtl/ltg_lane_id.sv
module ltg_lane_id
    import ltg_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [$clog2(LANES)-1:0] lane_idx,
    input  logic                     half_width,
    output logic [NIB_W-1:0]         lane_nib
);
    localparam int LW       = $clog2(LANES);
    localparam int TOP_FULL = LANES - 1;
    localparam int TOP_HALF = LANES / 2 - 1;

    logic [LW-1:0] top_lane;

    always_comb begin
        top_lane = half_width ? LW'(TOP_HALF) : LW'(TOP_FULL);
        if (lane_idx == '0)
            lane_nib = NIB_FIRST;
        else if (lane_idx == top_lane)
            lane_nib = NIB_LAST;
        else
            lane_nib = NIB_MID;
    end

    // R3
    always_comb begin
        lane_zero_chk: assert (lane_idx != '0 || lane_nib == NIB_FIRST)
            else $error("lane 0 nibble wrong");
    end
endmodule

// File: rtl/ltg_seq_ctr.sv
module ltg_seq_ctr
    import ltg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    output logic [SEQ_W-1:0] seq
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart)
            st_d.seq = '0;
        else if (advance)
            st_d.seq = st_q.seq + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seq = st_q.seq;

    // R6
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !restart |=> st_q.seq == SEQ_W'($past(st_q.seq) + 1'b1))
        else $error("sequence step wrong");

    // R10
    seq_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> st_q.seq == '0)
        else $error("sequence not cleared");
endmodule

// File: rtl/ltg_byte_tx.sv
module ltg_byte_tx
    import ltg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              stop_req,
    input  logic              out_ready,
    input  logic [NIB_W-1:0]  lane_nib,
    input  logic [SEQ_W-1:0]  seq,
    output logic              word_done,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid
);
    tx_state_t st_d, st_q;
    logic fire;
    logic go_null;

    always_comb begin
        fire    = st_q.valid && out_ready;
        go_null = stop_req || st_q.pend;
        st_d    = st_q;
        if (restart) begin
            st_d.valid  = 1'b1;
            st_d.phase  = 1'b0;
            st_d.nulled = 1'b0;
            st_d.pend   = 1'b0;
        end else begin
            st_d.valid = 1'b1;
            if (fire) begin
                if (!st_q.nulled)
                    st_d.phase = ~st_q.phase;
                if (go_null) begin
                    st_d.nulled = 1'b1;
                    st_d.pend   = 1'b0;
                end
            end else if (stop_req && !st_q.nulled) begin
                st_d.pend = 1'b1;
            end
        end
        word_done = fire && st_q.phase && !st_q.nulled && !restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (st_q.nulled)
            out_data = NULL_BYTE;
        else if (st_q.phase)
            out_data = HDR_BYTE;
        else
            out_data = {lane_nib, seq};
        out_valid = st_q.valid;
    end

    // R2
    phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !st_q.nulled && !restart |=> st_q.phase != $past(st_q.phase))
        else $error("byte order broken");

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid && !out_ready && !restart |=> $stable(st_q.phase) && $stable(st_q.nulled))
        else $error("state moved while stalled");

    // R8
    stop_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && stop_req && !restart |=> st_q.nulled)
        else $error("stop not applied after transfer");

    // R9
    null_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.nulled && !restart |=> st_q.nulled && out_data == NULL_BYTE)
        else $error("null output left without restart");

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> out_valid && !st_q.phase && !st_q.nulled && !st_q.pend)
        else $error("restart state wrong");

    // R1
    valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid)
        else $error("valid dropped");
endmodule

// File: rtl/lane_train_gen.sv
module lane_train_gen
    import ltg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] lane_idx,
    input  logic       half_width,
    input  logic       restart,
    input  logic       stop_req,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_valid
);
    localparam int LANES = 16;

    logic [NIB_W-1:0] lane_nib;
    logic [SEQ_W-1:0] seq;
    logic             word_done;

    ltg_lane_id #(.LANES(LANES)) u_lane (
        .lane_idx   (lane_idx),
        .half_width (half_width),
        .lane_nib   (lane_nib)
    );

    ltg_seq_ctr u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .advance (word_done),
        .seq     (seq)
    );

    ltg_byte_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .stop_req  (stop_req),
        .out_ready (out_ready),
        .lane_nib  (lane_nib),
        .seq       (seq),
        .word_done (word_done),
        .out_data  (out_data),
        .out_valid (out_valid)
    );
endmodule

// File: tb/sim_lane_train_gen.sv
module sim_lane_train_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] lane_idx = 4'd0;
    logic       half_width = 1'b0;
    logic       restart = 1'b0;
    logic       stop_req = 1'b0;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_valid;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    lane_train_gen u0 (
        .clk(clk), .rst_n(rst_n), .lane_idx(lane_idx), .half_width(half_width),
        .restart(restart), .stop_req(stop_req), .out_ready(out_ready),
        .out_data(out_data), .out_valid(out_valid)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // check offered byte, then let it transfer (out_ready must be 1)
    task automatic take(input string req, input logic [7:0] exp);
        chk({req, " valid"}, {7'd0, out_valid}, 8'd1);
        chk(req, out_data, exp);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_restart();
        restart = 1'b1;
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
    endtask

    function automatic logic [3:0] exp_nib(input int lane, input bit hw);
        if (lane == 0) return 4'h3;
        if (lane == (hw ? 7 : 15)) return 4'hC;
        return 4'h5;
    endfunction

    function automatic string nib_req(input int lane, input bit hw);
        if (lane == 0) return "R3";
        if (lane == (hw ? 7 : 15)) return "R4";
        return "R5";
    endfunction

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {7'd0, out_valid}, 8'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        take("R1 first byte", 8'h30);
        take("R1 first header", 8'hF0);

        // R2..R6: sweep every lane at both widths across a full pattern plus wrap
        for (int hw = 0; hw < 2; hw++) begin
            for (int lane = 0; lane < (hw ? 8 : 16); lane++) begin
                lane_idx = 4'(lane);
                half_width = 1'(hw);
                do_restart();
                for (int b = 0; b < 36; b++) begin
                    if (b % 2 == 1)
                        take("R2 header", 8'hF0);
                    else if (b >= 32)
                        take("R6 wrap", {exp_nib(lane, 1'(hw)), 4'((b / 2) % 16)});
                    else
                        take({nib_req(lane, 1'(hw)), " R6 low"},
                             {exp_nib(lane, 1'(hw)), 4'((b / 2) % 16)});
                end
            end
        end

        // R7: stall holds data
        lane_idx = 4'd3;
        half_width = 1'b0;
        do_restart();
        out_ready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R7 hold low", out_data, 8'h50);
            @(negedge clk);
        end
        out_ready = 1'b1;
        take("R7 low after stall", 8'h50);
        out_ready = 1'b0;
        @(negedge clk);
        chk("R7 hold high", out_data, 8'hF0);
        out_ready = 1'b1;
        take("R7 high after stall", 8'hF0);
        take("R7 next word", 8'h51);

        // R8: stop between bytes of a word
        do_restart();
        take("R8 pre", 8'h50);
        take("R8 pre", 8'hF0);
        stop_req = 1'b1;
        take("R8 last training byte", 8'h51);
        stop_req = 1'b0;
        for (int i = 0; i < 4; i++) take("R9 null persists", 8'h00);

        // R8: stop sampled during stall, applies after next transfer
        do_restart();
        take("R8 pre2", 8'h50);
        out_ready = 1'b0;
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        @(negedge clk);
        chk("R8 stalled high kept", out_data, 8'hF0);
        out_ready = 1'b1;
        take("R8 pending byte completes", 8'hF0);
        for (int i = 0; i < 3; i++) take("R9 null after pending", 8'h00);

        // R10: restart after null resumes at sequence 0
        do_restart();
        take("R10 resume low", 8'h50);
        take("R10 resume high", 8'hF0);
        take("R10 resume seq1", 8'h51);

        // R10: restart mid-pattern and priority over stop
        stop_req = 1'b1;
        restart = 1'b1;
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
        stop_req = 1'b0;
        take("R10 priority low", 8'h50);
        take("R10 priority high", 8'hF0);
        take("R10 still training", 8'h51);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule